// File: doc/BRIEF.md
# Conversion-Triggered Serial ADC Reader

This block is the host side of a link to a 12-bit sampling converter that is started by a dedicated conversion line and read through a serial clock and a serial data line. When a start request arrives in the idle state, the block raises the conversion line. It holds the line high for a fixed number of system clocks, which is the conversion time. It then lowers the line, which opens the data phase. During the data phase it runs a divided serial clock and samples the data line once per rising edge, most significant bit first.

When the last bit has been taken and the serial clock has returned low, the block presents the 12-bit unipolar code on a parallel output, together with a valid strobe that lasts one system clock. Code zero corresponds to zero differential input. The all-ones code corresponds to full scale, which is the reference minus one LSB. An optional check mode clocks four further bits after the result. The converter must return zeros for these bits, so any one raises an error flag that is reported with the strobe.

The state machine has five states:
- ST_IDLE waits for `start`.
- ST_CONVERT holds `conv_o` high for the conversion time.
- ST_SHIFT clocks the twelve data bits.
- ST_TRAIL clocks the four check bits.
- ST_FINISH raises the strobe for one cycle.

The transitions are:
- `start` moves ST_IDLE to ST_CONVERT.
- When the wait count expires, ST_CONVERT moves to ST_SHIFT.
- In ST_SHIFT, the falling edge after the 12th rising edge moves to ST_TRAIL when check mode is on, and to ST_FINISH otherwise.
- In ST_TRAIL, the falling edge after the 16th rising edge moves to ST_FINISH.
- ST_FINISH always moves to ST_IDLE.

Top module: `adc_conv_reader`

## Requirements
- R1: While reset is asserted and after it is released, `conv_o`, `sck_o`, `busy_o`, `result_valid_o` and `zero_err_o` are all 0.
- R2: A `start` pulse accepted in idle raises `conv_o` on the next clock edge. `conv_o` then stays high for exactly CONV_CYCLES system clocks before it falls.
- R3: `sck_o` is low while idle and while `conv_o` is high. In the data phase, each high phase of `sck_o` lasts `half_div`+1 system clocks, using `half_div` as sampled at start.
- R4: One conversion produces exactly 12 rising edges of `sck_o`, or 16 when `check_en` was 1 at start.
- R5: `sdo_i` is sampled on each rising edge of `sck_o`. The first sampled bit becomes bit 11 of `result_o`, so the result equals the 12-bit code the converter shifted out MSB first.
- R6: `result_valid_o` pulses high for exactly one system clock per conversion. During the pulse, `sck_o` and `conv_o` are both low.
- R7: A `start` that arrives while `busy_o` is 1 is ignored, so the conversion line rises once per accepted request.
- R8: With `check_en` set at start, `zero_err_o` is 1 at the strobe exactly when any of the four bits after the result is 1. With `check_en` clear, the bits after the result have no effect and `zero_err_o` is 0.
- R9: `busy_o` is 1 from the cycle `conv_o` rises through the strobe cycle, and it is 0 in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, accepted only in idle |
| half_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| check_en | input | 1 | Enables the four trailing zero-check bits |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion-control line to the converter |
| sck_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | A conversion or readout is in progress |
| result_o | output | DATA_W | Last captured conversion code |
| result_valid_o | output | 1 | One-cycle strobe marking a new result |
| zero_err_o | output | 1 | A trailing check bit was 1 |

## Verification
If the bit counter is wrong, the port shows the wrong number of serial clock edges and a result shifted by one or more positions. That misaligned result is visible at the first strobe. If the wait counter is wrong, the conversion pulse has the wrong length, and the bench measures that length on every conversion. If the state machine exits on the wrong edge, the strobe appears while the serial clock is still high, and the checker reports it in that same cycle. A wrong error-flag path shows up at the strobe as a wrong flag value, for either check mode setting.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SHIFT,
        ST_TRAIL,
        ST_FINISH
    } rd_state_t;

endpackage

// File: rtl/adc_sck_div.sv
module adc_sck_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise,
    output logic             fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             tick;

    assign tick = en && (cnt_q == half);
    assign rise = tick && !sck_q;
    assign fall = tick && sck_q;
    assign sck  = sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              take,
    input  logic              din,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_nx;

    assign word_nx = {word_q[DATA_W-2:0], din};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            data   <= '0;
        end else begin
            if (shift) word_q <= word_nx;
            if (take)  data   <= word_nx;
        end
    end

endmodule

// File: rtl/adc_conv_reader.sv
module adc_conv_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CHECK_BITS  = 4,
    parameter int CONV_CYCLES = 20,
    parameter int DIV_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              check_en,
    input  logic              sdo_i,
    output logic              conv_o,
    output logic              sck_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              zero_err_o
);

    localparam int TOTAL_BITS = DATA_W + CHECK_BITS;
    localparam int BW         = $clog2(TOTAL_BITS + 1);
    localparam int WW         = $clog2(CONV_CYCLES + 1);
    localparam logic [BW-1:0] DATA_END  = BW'(DATA_W);
    localparam logic [BW-1:0] DATA_LAST = BW'(DATA_W - 1);
    localparam logic [BW-1:0] TRAIL_END = BW'(TOTAL_BITS);
    localparam logic [WW-1:0] WAIT_LAST = WW'(CONV_CYCLES - 1);

    rd_state_t        state_q, state_nx;
    logic [WW-1:0]    wait_q;
    logic [BW-1:0]    bit_q;
    logic [DIV_W-1:0] div_q;
    logic             chk_q;
    logic             err_q;
    logic             div_en, sck_rise, sck_fall;
    logic             shift_en, take_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_nx = ST_CONVERT;
            ST_CONVERT: if (wait_q == WAIT_LAST) state_nx = ST_SHIFT;
            ST_SHIFT:   if (sck_fall && bit_q == DATA_END)
                            state_nx = chk_q ? ST_TRAIL : ST_FINISH;
            ST_TRAIL:   if (sck_fall && bit_q == TRAIL_END) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        conv_o         = 1'b0;
        busy_o         = 1'b1;
        result_valid_o = 1'b0;
        div_en         = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o         = 1'b0;
            ST_CONVERT: conv_o         = 1'b1;
            ST_SHIFT:   div_en         = 1'b1;
            ST_TRAIL:   div_en         = 1'b1;
            ST_FINISH:  result_valid_o = 1'b1;
            default:    busy_o         = 1'b0;
        endcase
    end

    assign shift_en   = sck_rise && (state_q == ST_SHIFT);
    assign take_en    = shift_en && (bit_q == DATA_LAST);
    assign zero_err_o = err_q;

    // counters, configuration and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            chk_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            wait_q <= (state_q == ST_CONVERT) ? wait_q + 1'b1 : '0;
            if (state_q == ST_IDLE)  bit_q <= '0;
            else if (sck_rise)       bit_q <= bit_q + 1'b1;
            if (state_q == ST_IDLE && start) begin
                div_q <= half_div;
                chk_q <= check_en;
                err_q <= 1'b0;
            end else if (state_q == ST_TRAIL && sck_rise && sdo_i) begin
                err_q <= 1'b1;
            end
        end
    end

    adc_sck_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (div_en),
        .half (div_q),
        .sck  (sck_o),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    adc_shift_in #(.DATA_W(DATA_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .shift(shift_en),
        .take (take_en),
        .din  (sdo_i),
        .data (result_o)
    );

endmodule

// File: rtl/adc_conv_reader_chk.sv
module adc_conv_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic conv_o,
    input logic sck_o,
    input logic busy_o,
    input logic result_valid_o,
    input logic zero_err_o
);

    AST_SCK_LOW_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sck_o); // R3

    AST_CONV_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> $past(start) && !$past(busy_o)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o); // R6

    AST_VALID_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> !sck_o && !conv_o); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !conv_o && !sck_o && !result_valid_o); // R9

    AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_err_o) |-> busy_o); // R8

endmodule

bind adc_conv_reader adc_conv_reader_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .conv_o        (conv_o),
    .sck_o         (sck_o),
    .busy_o        (busy_o),
    .result_valid_o(result_valid_o),
    .zero_err_o    (zero_err_o)
);

// File: tb/tb_adc_conv_reader.sv
`timescale 1ns/1ps
module tb_adc_conv_reader;

    localparam int CONV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half_div = '0;
    logic        check_en = 1'b0;
    logic        sdo;
    logic        conv, sck, busy, valid, zerr;
    logic [11:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    adc_conv_reader #(.CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .check_en(check_en), .sdo_i(sdo), .conv_o(conv), .sck_o(sck),
        .busy_o(busy), .result_o(result), .result_valid_o(valid),
        .zero_err_o(zerr)
    );

    // converter model: MSB shown on conv fall, next bit on each sck fall
    logic [11:0] m_code = '0;
    logic [3:0]  m_trail = '0;
    int          m_idx = 0;

    always @(posedge conv or negedge sck) begin
        if (conv) m_idx <= 0;
        else      m_idx <= m_idx + 1;
    end

    always_comb begin
        if (conv)              sdo = 1'b0;
        else if (m_idx < 12)   sdo = m_code[11 - m_idx];
        else if (m_idx < 16)   sdo = m_trail[15 - m_idx];
        else                   sdo = 1'b0;
    end

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // monitor sampled away from the active edge
    int  conv_hi = 0, rises = 0, conv_rises = 0, hi_run = 0, cur_half = 0;
    logic prev_sck = 0, prev_conv = 0;

    always @(negedge clk) begin
        if (conv) conv_hi++;
        if (conv && sck) check("R3 sck low while conv high", 1, 0);
        if (conv && !prev_conv) conv_rises++;
        if (sck && !prev_sck) rises++;
        if (sck) hi_run++;
        if (!sck && prev_sck) begin
            check("R3 sck high phase", hi_run, cur_half + 1);
            hi_run = 0;
        end
        prev_sck  = sck;
        prev_conv = conv;
    end

    task automatic run(input logic [11:0] code, input int half, input logic chk,
                       input logic [3:0] trail, input logic poke);
        int waited;
        int idle_busy;
        m_code = code; m_trail = trail;
        half_div = 8'(half); check_en = chk; cur_half = half;
        @(negedge clk);
        conv_hi = 0; rises = 0; conv_rises = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 conv rises after start", conv, 1);
        waited = 0; idle_busy = 0;
        while (!valid && waited < 2000) begin
            if (!busy) idle_busy++;
            if (poke && waited == 30) start = 1'b1;
            if (poke && waited == 31) start = 1'b0;
            @(negedge clk);
            waited++;
        end
        check("R6 strobe seen", valid, 1);
        check("R5 result", result, code);
        check("R2 conv high cycles", conv_hi, CONV);
        check("R4 rising edges", rises, chk ? 16 : 12);
        check("R8 error flag", zerr, (chk && (trail != 0)) ? 1 : 0);
        check("R6 lines low at strobe", {conv, sck}, 0);
        check("R9 busy through transfer", idle_busy, 0);
        check("R9 busy at strobe", busy, 1);
        @(negedge clk);
        check("R6 strobe one cycle", valid, 0);
        check("R9 idle after strobe", busy, 0);
        repeat (3) @(negedge clk);
        check("R7 single conversion", conv_rises, 1);
        check("R3 sck idle low", sck, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset conv", conv, 0);
        check("R1 reset sck", sck, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset valid", valid, 0);
        check("R1 reset err", zerr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {conv, sck, busy, valid, zerr}, 0);

        for (int h = 0; h < 3; h++) begin
            int hv;
            hv = (h == 2) ? 3 : h;
            run(12'h000, hv, 1'b0, 4'h0, 1'b0);
            run(12'hFFF, hv, 1'b0, 4'h0, 1'b0);
            for (int b = 0; b < 12; b++) run(12'(1 << b), hv, 1'b0, 4'h0, 1'b0);
            for (int k = 1; k < 28; k++) run(12'((k * 151) % 4096), hv, 1'b0, 4'h0, 1'b0);
        end

        // R8: trailing check bits
        for (int t = 0; t < 4; t++) run(12'hA5C, 1, 1'b1, 4'(1 << t), 1'b0);
        run(12'h3C3, 0, 1'b1, 4'h0, 1'b0);
        run(12'h3C3, 0, 1'b0, 4'hF, 1'b0);
        run(12'hFFF, 2, 1'b1, 4'h0, 1'b0);

        // R7: start while busy
        run(12'h5A5, 1, 1'b0, 4'h0, 1'b1);
        run(12'h1E7, 0, 1'b1, 4'h8, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule